// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is one channel of a direct-memory-access engine. Software loads three registers (a start address, a block word and a control word) and then sets the start flag in the control word. The channel then copies a counted run of 32-bit words in one of two directions: out of system memory and onto a stream toward a peripheral, or off a stream from the peripheral and into system memory. Memory is reached through a word-wide request/ready port. The peripheral side is a valid/ready stream in each direction.

The channel only starts on an exact control-word match. Any other word that carries the start flag is finished at once and moves nothing. The transfer is clipped at the end of the memory region. Even so, the address register is always advanced by the full requested length. At the end the start flag drops and a one-cycle interrupt pulse is produced.

Top module: `blk_dma_channel`

## Requirements
- R1: After reset all three registers read zero, `irq` is low, and neither `mem_req`, `dev_tx_valid` nor `dev_rx_ready` is asserted.
- R2: `reg_sel` picks the register for both write and read: 0 is the address, 1 the block word, 2 the control word, and 3 reads as zero. While bit 24 of the control register is set, every register write is ignored.
- R3: Control value 0x01000201 copies memory to the peripheral. Words are read from consecutive word addresses, starting at the address register with bits 1:0 cleared, and are delivered on `dev_tx_data` in that order.
- R4: Control value 0x01000200 copies the peripheral to memory. Words taken from `dev_rx_data` are written to consecutive word addresses, starting at the address register with bits 1:0 cleared.
- R5: The requested word count is the block word's bits 31:16 multiplied by its bits 15:0.
- R6: The number of words moved is the smaller of the requested count and the words left before byte address 2^MEM_ADDR_W. No memory request ever addresses at or beyond that limit.
- R7: At completion of a recognised pattern with a valid address, the address register becomes the start address with bits 1:0 cleared, plus 4 × the requested count (modulo 2^32). This holds whether or not the transfer was clipped.
- R8: At completion bit 24 of the control register is cleared and its other bits are kept. `irq` is high for exactly one cycle.
- R9: A control word with bit 24 set that matches neither pattern moves no data. It raises `irq` within two cycles of the write and leaves the address register unchanged.
- R10: A start address with any bit at or above MEM_ADDR_W set moves no data. It raises `irq` within two cycles and leaves the address register unchanged.
- R11: A requested count of zero moves no data. It raises `irq` within two cycles and sets the address register to the start address with bits 1:0 cleared.
- R12: Writing a control word with bit 24 clear starts nothing and raises no interrupt.
- R13: `mem_req` keeps `mem_addr` stable until `mem_ready`. `dev_tx_valid` keeps `dev_tx_data` stable until `dev_tx_ready`. One word moves per accepted memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 block, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| dev_tx_valid | output | 1 | Word offered to the peripheral |
| dev_tx_data | output | 32 | Word to the peripheral |
| dev_tx_ready | input | 1 | Peripheral takes the word |
| dev_rx_valid | input | 1 | Peripheral offers a word |
| dev_rx_data | input | 32 | Word from the peripheral |
| dev_rx_ready | output | 1 | Channel takes the word |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The copy function is run in both directions with ready signals always high and with periodic stalls on the memory and peripheral sides. The stalled runs show that words are neither dropped nor repeated when a handshake waits. Block words whose two factors differ, such as 2×3 and 4×2, show that the count is a product and not a sum or a single field. An unaligned start address separates the aligned base from the raw one. Starts placed near the top of the region, in both directions, separate the clipped move count from the full-length address update. The rejected cases are an off-pattern control word, an out-of-region address, a zero count and a start flag left clear. They show that only the start flag together with an exact match moves data, and which of these cases rewrite the address.

// File: rtl/dma_chan_pkg.sv
// Shared constants and types for the block-transfer DMA channel.
// Assumes 32-bit registers and a 32-bit data path.
package dma_chan_pkg;

    localparam int          BUSY_BIT      = 24;
    localparam logic [31:0] CTRL_TO_DEV   = 32'h0100_0201;
    localparam logic [31:0] CTRL_FROM_DEV = 32'h0100_0200;

    localparam logic [1:0]  SEL_ADDR  = 2'd0;
    localparam logic [1:0]  SEL_BLOCK = 2'd1;
    localparam logic [1:0]  SEL_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_TO_DEV   = 2'd1,
        OP_FROM_DEV = 2'd2
    } dma_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MREAD = 3'd1,
        ST_TXOUT = 3'd2,
        ST_RXIN  = 3'd3,
        ST_MWRIT = 3'd4,
        ST_FIN   = 3'd5
    } eng_state_e;

endpackage

// File: rtl/dma_cmd_decode.sv
// Maps the full control word to a transfer operation.
// Assumes that only an exact match of all 32 bits selects a direction.
module dma_cmd_decode
    import dma_chan_pkg::*;
(
    input  logic [31:0] ctrl,
    output dma_op_e     op
);

    // exact-pattern decode; anything else is OP_NONE
    always_comb begin
        if (ctrl == CTRL_TO_DEV)
            op = OP_TO_DEV;
        else if (ctrl == CTRL_FROM_DEV)
            op = OP_FROM_DEV;
        else
            op = OP_NONE;
    end

endmodule

// File: rtl/dma_len_calc.sv
// Length and address arithmetic for one block transfer.
// Assumes the memory region spans byte addresses 0 .. 2^MEM_ADDR_W-1,
// and that move_words is only used when addr_ok is true.
module dma_len_calc #(
    parameter int MEM_ADDR_W = 21,
    parameter int CNT_W      = MEM_ADDR_W - 1
) (
    input  logic [31:0]      madr,
    input  logic [31:0]      bcr,
    output logic [31:0]      aligned,
    output logic             addr_ok,
    output logic             zero_len,
    output logic [CNT_W-1:0] move_words,
    output logic [31:0]      end_addr
);

    localparam logic [MEM_ADDR_W:0] REGION = {1'b1, {MEM_ADDR_W{1'b0}}};

    logic [31:0]         total;
    logic [MEM_ADDR_W:0] span;
    logic [CNT_W-1:0]    avail;

    // word-aligned base and region check
    always_comb begin
        aligned = {madr[31:2], 2'b00};
        addr_ok = (madr >> MEM_ADDR_W) == 32'd0;
    end

    // requested count, room left in region, and clipped count
    always_comb begin
        total      = 32'(bcr[31:16]) * 32'(bcr[15:0]);
        zero_len   = (total == 32'd0);
        span       = REGION - {1'b0, aligned[MEM_ADDR_W-1:0]};
        avail      = span[MEM_ADDR_W:2];
        move_words = (total < 32'(avail)) ? total[CNT_W-1:0] : avail;
    end

    // address written back: full requested length, regardless of clipping
    always_comb begin
        end_addr = aligned + (total << 2);
    end

endmodule

// File: rtl/dma_xfer_engine.sv
// Word-by-word mover for one block transfer.
// Latches base and count at start. In memory-to-device mode it alternates
// a memory read and a stream send; in device-to-memory mode it alternates
// a stream receive and a memory write. It holds ST_FIN for one cycle.
// Assumes start is only raised while idle.
module dma_xfer_engine
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             go,
    input  logic             to_dev,
    input  logic [31:0]      base,
    input  logic [CNT_W-1:0] words,
    output logic             idle,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    output logic             tx_valid,
    output logic [31:0]      tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [31:0]      rx_data,
    output logic             rx_ready
);

    eng_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] words_q;
    logic [31:0]      base_q;
    logic [31:0]      data_q;
    logic             last;

    assign last = (CNT_W'(cnt_q + 1'b1) == words_q);

    // state, counter and data holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            words_q <= '0;
            base_q  <= '0;
            data_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        words_q <= words;
                        base_q  <= base;
                        if (!go)
                            st_q <= ST_FIN;
                        else if (to_dev)
                            st_q <= ST_MREAD;
                        else
                            st_q <= ST_RXIN;
                    end
                end
                ST_MREAD: begin
                    if (mem_ready) begin
                        data_q <= mem_rdata;
                        st_q   <= ST_TXOUT;
                    end
                end
                ST_TXOUT: begin
                    if (tx_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        st_q  <= last ? ST_FIN : ST_MREAD;
                    end
                end
                ST_RXIN: begin
                    if (rx_valid) begin
                        data_q <= rx_data;
                        st_q   <= ST_MWRIT;
                    end
                end
                ST_MWRIT: begin
                    if (mem_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        st_q  <= last ? ST_FIN : ST_RXIN;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // port drive from state
    always_comb begin
        idle      = (st_q == ST_IDLE);
        done      = (st_q == ST_FIN);
        mem_req   = (st_q == ST_MREAD) || (st_q == ST_MWRIT);
        mem_we    = (st_q == ST_MWRIT);
        mem_addr  = base_q + 32'({cnt_q, 2'b00});
        mem_wdata = data_q;
        tx_valid  = (st_q == ST_TXOUT);
        tx_data   = data_q;
        rx_ready  = (st_q == ST_RXIN);
    end

endmodule

// File: rtl/blk_dma_channel.sv
// Block-transfer DMA channel top: register file, start logic and write-back.
// Registers can be written only while the busy flag (control bit 24) is
// clear. A start is taken when the engine is idle and the flag is set.
// Assumes a single master on the register port.
module blk_dma_channel
    import dma_chan_pkg::*;
#(
    parameter int MEM_ADDR_W = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        irq
);

    localparam int CNT_W = MEM_ADDR_W - 1;

    logic [31:0]      madr_q;
    logic [31:0]      bcr_q;
    logic [31:0]      ctrl_q;
    dma_op_e          op;
    logic [31:0]      aligned;
    logic             addr_ok;
    logic             zero_len;
    logic [CNT_W-1:0] move_words;
    logic [31:0]      end_addr;
    logic             eng_idle;
    logic             eng_done;
    logic             start;
    logic             go;
    logic             busy;

    assign busy  = ctrl_q[BUSY_BIT];
    assign start = eng_idle && busy;
    assign go    = (op != OP_NONE) && addr_ok && !zero_len;

    dma_cmd_decode u_dec (
        .ctrl (ctrl_q),
        .op   (op)
    );

    dma_len_calc #(
        .MEM_ADDR_W (MEM_ADDR_W),
        .CNT_W      (CNT_W)
    ) u_len (
        .madr       (madr_q),
        .bcr        (bcr_q),
        .aligned    (aligned),
        .addr_ok    (addr_ok),
        .zero_len   (zero_len),
        .move_words (move_words),
        .end_addr   (end_addr)
    );

    dma_xfer_engine #(
        .CNT_W (CNT_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .go        (go),
        .to_dev    (op == OP_TO_DEV),
        .base      (aligned),
        .words     (move_words),
        .idle      (eng_idle),
        .done      (eng_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .tx_valid  (dev_tx_valid),
        .tx_data   (dev_tx_data),
        .tx_ready  (dev_tx_ready),
        .rx_valid  (dev_rx_valid),
        .rx_data   (dev_rx_data),
        .rx_ready  (dev_rx_ready)
    );

    // register writes while not busy; write-back and flag clear at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            madr_q <= '0;
            bcr_q  <= '0;
            ctrl_q <= '0;
        end else if (eng_done) begin
            ctrl_q[BUSY_BIT] <= 1'b0;
            if ((op != OP_NONE) && addr_ok)
                madr_q <= end_addr;
        end else if (reg_we && !busy) begin
            case (reg_sel)
                SEL_ADDR:  madr_q <= reg_wdata;
                SEL_BLOCK: bcr_q  <= reg_wdata;
                SEL_CTRL:  ctrl_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // register read mux
    always_comb begin
        case (reg_sel)
            SEL_ADDR:  reg_rdata = madr_q;
            SEL_BLOCK: reg_rdata = bcr_q;
            SEL_CTRL:  reg_rdata = ctrl_q;
            default:   reg_rdata = 32'd0;
        endcase
    end

    assign irq = eng_done;

endmodule

// File: rtl/dma_chan_checker.sv
// Protocol and completion properties for blk_dma_channel, attached by bind.
module dma_chan_checker #(
    parameter int MEM_ADDR_W = 21
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        irq,
    input logic        mem_req,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        dev_tx_valid,
    input logic [31:0] dev_tx_data,
    input logic        dev_tx_ready,
    input logic        dev_rx_ready
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                    // R8

    AST_IRQ_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);                                                   // R8

    AST_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);                                                    // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));      // R13

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data))); // R13

    AST_MEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr >> MEM_ADDR_W) == 32'd0));                 // R6

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_tx_valid && dev_rx_ready));                                 // R3

    AST_MOVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || dev_tx_valid || dev_rx_ready) |-> busy);              // R12

endmodule

bind blk_dma_channel dma_chan_checker #(.MEM_ADDR_W(MEM_ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (ctrl_q[24]),
    .irq          (irq),
    .mem_req      (mem_req),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_data  (dev_tx_data),
    .dev_tx_ready (dev_tx_ready),
    .dev_rx_ready (dev_rx_ready)
);

// File: tb/tb_blk_dma_channel.sv
`timescale 1ns/1ps
module tb_blk_dma_channel;

    localparam int AW    = 12;
    localparam int WORDS = 1 << (AW - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic        dev_tx_valid, dev_tx_ready = 1'b1;
    logic [31:0] dev_tx_data;
    logic        dev_rx_valid = 1'b0, dev_rx_ready;
    logic [31:0] dev_rx_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sink_n = 0;
    int src_n = 0;
    int irq_n = 0;
    bit stall_en = 1'b0;
    logic [31:0] mem [0:WORDS-1];
    logic [31:0] sink [0:63];

    always #2 clk = ~clk;

    blk_dma_channel #(.MEM_ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready), .irq(irq)
    );

    assign mem_rdata   = mem[mem_addr[AW-1:2]];
    assign dev_rx_data = 32'hA500_0000 + 32'(src_n);

    // stall patterns change away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready    <= stall_en ? ((cyc % 3) != 1) : 1'b1;
        dev_tx_ready <= stall_en ? ((cyc % 4) != 2) : 1'b1;
    end

    // memory, sink, source and interrupt models
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready)
            mem[mem_addr[AW-1:2]] <= mem_wdata;
        if (dev_tx_valid && dev_tx_ready) begin
            if (sink_n < 64) sink[sink_n] <= dev_tx_data;
            sink_n <= sink_n + 1;
        end
        if (dev_rx_valid && dev_rx_ready)
            src_n <= src_n + 1;
        if (irq)
            irq_n <= irq_n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic prefill();
        for (int i = 0; i < WORDS; i++) mem[i] = 32'h1000_0000 + 32'(i);
    endtask

    // waits for irq at negedges; returns cycles waited, -1 on timeout
    task automatic wait_irq(input int limit, output int waited);
        waited = -1;
        for (int i = 1; i <= limit; i++) begin
            if (irq) begin waited = i; break; end
            @(negedge clk);
        end
        if (waited == -1 && irq) waited = limit;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        wr(2'd0, a);
        wr(2'd1, b);
        wr(2'd2, c);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v == 0, "R1", "addr after reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1", "block after reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
        chk(!irq && !mem_req && !dev_tx_valid && !dev_rx_ready, "R1", "outputs idle",
            {28'd0, irq, mem_req, dev_tx_valid, dev_rx_ready}, 0);
        rd(2'd3, v); chk(v == 0, "R2", "select 3 reads zero", v, 0);
    endtask

    // memory to device; checks order, count, write-back and flag clear
    task automatic t_to_dev(input logic [31:0] a, input logic [31:0] b, input int nmove,
                            input logic [31:0] exp_adr, input bit stall, input bit poke);
        int s0, i0, w;
        logic [31:0] v;
        prefill();
        stall_en = stall;
        s0 = sink_n; i0 = irq_n;
        start(a, b, 32'h0100_0201);
        if (poke) begin
            wr(2'd0, 32'h0000_0ABC);
            rd(2'd0, v); chk(v == a, "R2", "address write ignored while busy", v, a);
        end
        wait_irq(400, w);
        chk(w > 0, "R8", "irq seen", 32'(w), 1);
        chk(sink_n - s0 == nmove, "R6", "words delivered", 32'(sink_n - s0), 32'(nmove));
        for (int k = 0; k < nmove && k < 64; k++)
            chk(sink[s0 + k] == 32'h1000_0000 + 32'(a[AW-1:2]) + 32'(k), "R3", "word order",
                sink[s0 + k], 32'h1000_0000 + 32'(a[AW-1:2]) + 32'(k));
        rd(2'd0, v); chk(v == exp_adr, "R7", "address write-back", v, exp_adr);
        rd(2'd2, v); chk(v == 32'h0000_0201, "R8", "busy flag cleared", v, 32'h0000_0201);
        chk(irq_n - i0 == 1, "R8", "single irq pulse", 32'(irq_n - i0), 1);
        stall_en = 1'b0;
    endtask

    // device to memory
    task automatic t_from_dev(input logic [31:0] a, input logic [31:0] b, input int nmove,
                              input logic [31:0] exp_adr);
        int r0, w;
        int base;
        logic [31:0] v;
        prefill();
        stall_en = 1'b1;
        base = int'(a[AW-1:2]);
        r0 = src_n;
        dev_rx_valid = 1'b1;
        start(a, b, 32'h0100_0200);
        wait_irq(400, w);
        dev_rx_valid = 1'b0;
        chk(w > 0, "R8", "irq seen", 32'(w), 1);
        chk(src_n - r0 == nmove, "R6", "words taken", 32'(src_n - r0), 32'(nmove));
        for (int k = 0; k < nmove; k++)
            chk(mem[base + k] == 32'hA500_0000 + 32'(r0 + k), "R4", "memory word",
                mem[base + k], 32'hA500_0000 + 32'(r0 + k));
        if (base + nmove < WORDS)
            chk(mem[base + nmove] == 32'h1000_0000 + 32'(base + nmove), "R4", "word past end untouched",
                mem[base + nmove], 32'h1000_0000 + 32'(base + nmove));
        rd(2'd0, v); chk(v == exp_adr, "R7", "address write-back", v, exp_adr);
        rd(2'd2, v); chk(v == 32'h0000_0200, "R8", "busy flag cleared", v, 32'h0000_0200);
        stall_en = 1'b0;
    endtask

    // cases that finish at once without moving data
    task automatic t_no_move(input string req, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input logic [31:0] exp_adr);
        int s0, r0, w;
        logic [31:0] v;
        s0 = sink_n; r0 = src_n;
        dev_rx_valid = 1'b1;
        start(a, b, c);
        wait_irq(3, w);
        dev_rx_valid = 1'b0;
        chk(w > 0, req, "prompt irq", 32'(w), 1);
        chk(sink_n == s0 && src_n == r0 && !mem_req, req, "no data moved",
            32'(sink_n - s0 + src_n - r0), 0);
        rd(2'd0, v); chk(v == exp_adr, req, "address register", v, exp_adr);
        rd(2'd2, v); chk(v == (c & ~32'h0100_0000), req, "ctrl flag cleared", v, c & ~32'h0100_0000);
    endtask

    task automatic t_flag_clear();
        int i0, s0;
        logic [31:0] v;
        i0 = irq_n; s0 = sink_n;
        start(32'h0000_0100, 32'h0001_0001, 32'h0000_0201);
        repeat (10) @(negedge clk);
        chk(irq_n == i0, "R12", "no irq without start flag", 32'(irq_n - i0), 0);
        chk(sink_n == s0, "R12", "no data without start flag", 32'(sink_n - s0), 0);
        wr(2'd0, 32'h0000_0040);
        rd(2'd0, v); chk(v == 32'h0000_0040, "R2", "write accepted while idle", v, 32'h0000_0040);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        prefill();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R3 R5: 2 blocks x 3 words, no stalls
        t_to_dev(32'h0000_0100, 32'h0002_0003, 6, 32'h0000_0118, 1'b0, 1'b0);
        // R13 R2: unaligned start, 4 x 2 words, stalls, write attempt while busy
        t_to_dev(32'h0000_0203, 32'h0004_0002, 8, 32'h0000_0220, 1'b1, 1'b1);
        // R4: 1 x 5 words
        t_from_dev(32'h0000_0300, 32'h0001_0005, 5, 32'h0000_0314);
        // R6 R7: clipped at region end
        t_to_dev(32'h0000_0FF0, 32'h0002_0004, 4, 32'h0000_1010, 1'b1, 1'b0);
        t_from_dev(32'h0000_0FF8, 32'h0001_0003, 2, 32'h0000_1004);
        // R9: off-pattern control word
        t_no_move("R9", 32'h0000_0100, 32'h0001_0004, 32'h0100_0202, 32'h0000_0100);
        // R10: address outside region
        t_no_move("R10", 32'h0000_1000, 32'h0001_0004, 32'h0100_0201, 32'h0000_1000);
        // R11: zero count, unaligned address becomes aligned
        t_no_move("R11", 32'h0000_0046, 32'h0000_0007, 32'h0100_0201, 32'h0000_0044);
        t_flag_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule